// File: doc/BRIEF.md
# Fetch-versus-Execute Stream Comparator

This block watches a processor from the outside and checks that what the core executes is what it fetched. On the system bus it snoops every read that carries the instruction-fetch qualifier and records the address and the word that memory returned. On the trace port it receives each retired instruction as a program counter plus instruction word. Fetched pairs wait in a small buffer. Each retired instruction is looked up in that buffer, so the two streams are brought back into step. Fetches that were never executed, such as wrong-path fetches after a taken branch, are discarded during this lookup.

An executed PC that was never fetched points to a control-flow error. A matching PC that carries a different instruction word points to corrupted data somewhere between memory and the pipeline. Either case raises a sticky error flag and records the PC that caused it. If the fetch side runs too far ahead and the buffer cannot take another entry, a separate overflow flag stops monitoring until software pulses the clear input.

Both input streams are observe-only, so they carry a valid strobe and no ready. The block never stalls the bus or the trace port. A snooped read or a trace record is taken in the cycle its valid is high and is never presented again. Loss of data is reported through the overflow flag and is never signalled back to the source.

Top module: `fetch_exec_cmp`

## Requirements
- R1: After reset, err_flag, err_word and ovf_flag are 0, err_pc is 0 and the buffer is empty, so the first trace record raises a not-fetched error.
- R2: A bus read is recorded only in a cycle where bus_rd_valid and bus_ifetch are both 1. A read with bus_ifetch at 0 leaves the buffer unchanged.
- R3: When trace records arrive in fetch order and carry the fetched PC and word, no error is raised.
- R4: When a trace PC matches a buffered entry that is not the oldest, every older entry is discarded without error. The matched entry is consumed as well, so a later trace of a discarded PC raises an error.
- R5: A trace record whose PC matches no buffered entry, including the case of an empty buffer, raises the error with err_word=0 and empties the buffer.
- R6: A trace record whose PC matches the oldest matching entry but whose word differs raises the error with err_word=1 and consumes entries up to that match.
- R7: Once err_flag is 1, it stays 1, and err_pc and err_word keep the values of the first offending record until clear, even if later errors occur.
- R8: A cycle with err_clr=1 zeroes err_flag, err_pc, err_word and ovf_flag and empties the buffer. Bus and trace inputs in that cycle are ignored.
- R9: A capture that finds DEPTH entries still held sets ovf_flag. Removals by a trace record in the same cycle are counted first. While ovf_flag is 1, no capture and no trace comparison takes place, so no error can be raised.
- R10: A trace record is compared against the buffer as it stood before any capture in the same cycle. Flags change at the clock edge that samples the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_rd_valid | input | 1 | A read is completing on the bus this cycle |
| bus_ifetch | input | 1 | The completing read is an instruction fetch |
| bus_addr | input | 32 | Address of the completing read |
| bus_rdata | input | 32 | Data returned by memory |
| trc_valid | input | 1 | A retired instruction is reported this cycle |
| trc_pc | input | 32 | PC of the retired instruction |
| trc_insn | input | 32 | Word of the retired instruction |
| err_clr | input | 1 | Clears the flags and empties the buffer |
| err_flag | output | 1 | Sticky stream mismatch indication |
| err_pc | output | 32 | PC of the first offending trace record |
| err_word | output | 1 | 1 if the first error was a word mismatch, 0 if the PC was not found |
| ovf_flag | output | 1 | Buffer overflow occurred; monitoring halted |

## Verification
The assertions check the following on every cycle:
- The buffer occupancy stays bounded.
- The lookup never consumes more entries than are held.
- No capture is made into a full buffer.
- The flags stay sticky, and the latched PC and cause stay frozen.
- The buffer is frozen while halted.
- A clear fully resets the state.
- A miss latches the trace PC one cycle later.

Some behaviour can only be shown by the bench's scenarios:
- Data reads are ignored.
- Wrong-path entries are discarded, as seen through a later trace of a discarded PC.
- A same-cycle capture does not take part in that cycle's comparison.
- The full randomized interleaving of fetch runs, branches, corrupted words and clears agrees with an independent queue model.

// File: rtl/fec_pkg.sv
package fec_pkg;
  parameter int FEC_ADDR_W = 32;
  parameter int FEC_WORD_W = 32;

  typedef struct packed {
    logic [FEC_ADDR_W-1:0] addr;
    logic [FEC_WORD_W-1:0] word;
  } fec_entry_t;
endpackage

// File: rtl/fec_fifo.sv
module fec_fifo
  import fec_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  fec_entry_t                   push_entry,
  input  logic [CNT_W-1:0]             pop_n,
  output logic [CNT_W-1:0]             cnt,
  output fec_entry_t [DEPTH-1:0]       view
);
  // DEPTH must be a power of two: pointers wrap by truncation.
  fec_entry_t mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      rd_ptr <= rd_ptr + pop_n[PTR_W-1:0];
      if (push) wr_ptr <= wr_ptr + PTR_W'(1);
      cnt <= cnt - pop_n + CNT_W'(push);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= push_entry;
  end

  // Entries presented oldest first.
  for (genvar i = 0; i < DEPTH; i++) begin : g_view
    assign view[i] = mem[rd_ptr + PTR_W'(i)];
  end

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));
  assert_pop_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> pop_n <= cnt);
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !flush) |-> (cnt - pop_n) < CNT_W'(DEPTH));
endmodule

// File: rtl/fec_match.sv
module fec_match
  import fec_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  fec_entry_t [DEPTH-1:0]  view,
  input  logic [CNT_W-1:0]        cnt,
  input  logic [FEC_ADDR_W-1:0]   pc,
  input  logic [FEC_WORD_W-1:0]   word,
  output logic                    found,
  output logic                    word_eq,
  output logic [CNT_W-1:0]        pop_n
);
  logic [CNT_W-1:0] idx;

  // Oldest matching entry wins: scan from youngest so the last hit kept is oldest.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if ((i < int'(cnt)) && (view[i].addr == pc)) begin
        found = 1'b1;
        idx   = CNT_W'(i);
      end
    end
    word_eq = (view[idx[PTR_W-1:0]].word == word);
    pop_n   = found ? (idx + CNT_W'(1)) : cnt;
  end
endmodule

// File: rtl/fec_flags.sv
module fec_flags
  import fec_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  miss,
  input  logic                  bad_word,
  input  logic                  ovf_evt,
  input  logic [FEC_ADDR_W-1:0] pc,
  output logic                  err_flag,
  output logic [FEC_ADDR_W-1:0] err_pc,
  output logic                  err_word,
  output logic                  ovf_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag <= 1'b0;
      err_pc   <= '0;
      err_word <= 1'b0;
      ovf_flag <= 1'b0;
    end else if (clr) begin
      err_flag <= 1'b0;
      err_pc   <= '0;
      err_word <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      if ((miss || bad_word) && !err_flag) begin
        err_flag <= 1'b1;
        err_pc   <= pc;
        err_word <= bad_word;
      end
      if (ovf_evt) ovf_flag <= 1'b1;
    end
  end

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !clr) |=> err_flag);
  assert_err_pc_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !clr) |=> ($stable(err_pc) && $stable(err_word)));
  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr) |=> ovf_flag);
endmodule

// File: rtl/fetch_exec_cmp.sv
module fetch_exec_cmp
  import fec_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_rd_valid,
  input  logic                  bus_ifetch,
  input  logic [FEC_ADDR_W-1:0] bus_addr,
  input  logic [FEC_WORD_W-1:0] bus_rdata,
  input  logic                  trc_valid,
  input  logic [FEC_ADDR_W-1:0] trc_pc,
  input  logic [FEC_WORD_W-1:0] trc_insn,
  input  logic                  err_clr,
  output logic                  err_flag,
  output logic [FEC_ADDR_W-1:0] err_pc,
  output logic                  err_word,
  output logic                  ovf_flag
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  fec_entry_t [DEPTH-1:0] view;
  fec_entry_t             cap_entry;
  logic [CNT_W-1:0]       cnt, match_pop, pop_sel, cnt_after;
  logic                   found, word_eq;
  logic                   fe, tr, push, ovf_evt, miss, bad_word;

  assign tr        = trc_valid && !ovf_flag && !err_clr;
  assign fe        = bus_rd_valid && bus_ifetch && !ovf_flag && !err_clr;
  assign pop_sel   = tr ? match_pop : '0;
  assign cnt_after = cnt - pop_sel;
  assign ovf_evt   = fe && (cnt_after == CNT_W'(DEPTH));
  assign push      = fe && !ovf_evt;
  assign miss      = tr && !found;
  assign bad_word  = tr && found && !word_eq;
  assign cap_entry = '{addr: bus_addr, word: bus_rdata};

  fec_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(err_clr), .push(push),
    .push_entry(cap_entry), .pop_n(pop_sel), .cnt(cnt), .view(view)
  );

  fec_match #(.DEPTH(DEPTH)) u_match (
    .view(view), .cnt(cnt), .pc(trc_pc), .word(trc_insn),
    .found(found), .word_eq(word_eq), .pop_n(match_pop)
  );

  fec_flags u_flags (
    .clk(clk), .rst_n(rst_n), .clr(err_clr), .miss(miss), .bad_word(bad_word),
    .ovf_evt(ovf_evt), .pc(trc_pc), .err_flag(err_flag), .err_pc(err_pc),
    .err_word(err_word), .ovf_flag(ovf_flag)
  );

  assert_halt_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !err_clr) |=> $stable(cnt));
  assert_clr_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> (cnt == '0 && !err_flag && !ovf_flag));
  assert_miss_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && !err_flag) |=> (err_flag && !err_word && err_pc == $past(trc_pc)));
  assert_miss_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && !fe) |=> cnt == '0);
endmodule

// File: tb/sim_fetch_exec_cmp.sv
module sim_fetch_exec_cmp;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rd_valid = 0, bus_ifetch = 0, trc_valid = 0, err_clr = 0;
  logic [31:0] bus_addr = 0, bus_rdata = 0, trc_pc = 0, trc_insn = 0;
  logic        err_flag, err_word, ovf_flag;
  logic [31:0] err_pc;

  always #10 clk = ~clk;

  fetch_exec_cmp #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_rd_valid(bus_rd_valid), .bus_ifetch(bus_ifetch),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .trc_valid(trc_valid),
    .trc_pc(trc_pc), .trc_insn(trc_insn), .err_clr(err_clr),
    .err_flag(err_flag), .err_pc(err_pc), .err_word(err_word), .ovf_flag(ovf_flag)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference model state
  logic [63:0] mq[$];
  bit          m_err, m_word, m_ovf;
  logic [31:0] m_pc;

  function automatic logic [31:0] word_of(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cmp_all(string tag);
    chk(tag, "err_flag", 32'(err_flag), 32'(m_err));
    chk(tag, "ovf_flag", 32'(ovf_flag), 32'(m_ovf));
    chk(tag, "err_pc", err_pc, m_pc);
    chk(tag, "err_word", 32'(err_word), 32'(m_word));
  endtask

  task automatic model(bit f, bit q, logic [31:0] a, logic [31:0] d,
                       bit t, logic [31:0] p, logic [31:0] w, bit c);
    bit miss = 0, bad = 0;
    int idx = -1;
    if (c) begin
      mq.delete();
      m_err = 0; m_word = 0; m_ovf = 0; m_pc = 0;
    end else if (!m_ovf) begin
      if (t) begin
        for (int k = 0; k < mq.size(); k++)
          if (idx < 0 && mq[k][63:32] == p) idx = k;
        if (idx < 0) begin
          miss = 1; mq.delete();
        end else begin
          if (mq[idx][31:0] != w) bad = 1;
          for (int k = 0; k <= idx; k++) void'(mq.pop_front());
        end
      end
      if (f && q) begin
        if (mq.size() == DEPTH) m_ovf = 1;
        else mq.push_back({a, d});
      end
      if ((miss || bad) && !m_err) begin
        m_err = 1; m_pc = p; m_word = bad;
      end
    end
  endtask

  // Called at a negedge; returns at the next negedge after the edge that used the inputs.
  task automatic step(bit f, bit q, logic [31:0] a, logic [31:0] d,
                      bit t, logic [31:0] p, logic [31:0] w, bit c, string tag);
    bus_rd_valid = f; bus_ifetch = q; bus_addr = a; bus_rdata = d;
    trc_valid = t; trc_pc = p; trc_insn = w; err_clr = c;
    @(posedge clk);
    model(f, q, a, d, t, p, w, c);
    @(negedge clk);
    cmp_all(tag);
  endtask

  task automatic fetch(logic [31:0] a, string tag);
    step(1, 1, a, word_of(a), 0, 0, 0, 0, tag);
  endtask
  task automatic exec(logic [31:0] p, string tag);
    step(0, 0, 0, 0, 1, p, word_of(p), 0, tag);
  endtask
  task automatic clear(string tag);
    step(0, 0, 0, 0, 0, 0, 0, 1, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    m_err = 0; m_word = 0; m_ovf = 0; m_pc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "err_flag", 32'(err_flag), 0);
    chk("R1", "ovf_flag", 32'(ovf_flag), 0);
    chk("R1", "err_pc", err_pc, 0);
    exec(32'h40, "R1");
    chk("R1", "empty-miss", 32'(err_flag), 1);
    clear("R8");

    // R2: data read is not captured
    step(1, 0, 32'h100, word_of(32'h100), 0, 0, 0, 0, "R2");
    step(0, 1, 32'h104, word_of(32'h104), 0, 0, 0, 0, "R2");
    exec(32'h100, "R2");
    chk("R2", "err_flag", 32'(err_flag), 1);
    chk("R2", "err_pc", err_pc, 32'h100);
    clear("R8");

    // R3: in-order stream
    for (int i = 0; i < 4; i++) fetch(32'h200 + 32'(4 * i), "R3");
    for (int i = 0; i < 4; i++) exec(32'h200 + 32'(4 * i), "R3");
    chk("R3", "err_flag", 32'(err_flag), 0);

    // R4: wrong-path fetches dropped
    fetch(32'h300, "R4"); fetch(32'h304, "R4"); fetch(32'h308, "R4"); fetch(32'h500, "R4");
    exec(32'h300, "R4");
    exec(32'h500, "R4");
    chk("R4", "no-err", 32'(err_flag), 0);
    exec(32'h304, "R4");
    chk("R4", "dropped-miss", 32'(err_flag), 1);
    chk("R4", "err_pc", err_pc, 32'h304);
    clear("R8");

    // R6 then R7
    fetch(32'h600, "R6");
    step(0, 0, 0, 0, 1, 32'h600, 32'hDEAD_BEEF, 0, "R6");
    chk("R6", "err_word", 32'(err_word), 1);
    chk("R6", "err_pc", err_pc, 32'h600);
    fetch(32'h604, "R7");
    exec(32'h999, "R7");
    chk("R7", "err_pc", err_pc, 32'h600);
    chk("R7", "err_word", 32'(err_word), 1);
    fetch(32'h700, "R8");
    // R8: clear with simultaneous inputs ignored
    step(1, 1, 32'h704, word_of(32'h704), 1, 32'h700, word_of(32'h700), 1, "R8");
    chk("R8", "err_flag", 32'(err_flag), 0);
    chk("R8", "err_pc", err_pc, 0);
    exec(32'h704, "R8");
    chk("R8", "buf-empty", 32'(err_flag), 1);
    clear("R8");

    // R9: overflow and halt
    for (int i = 0; i < DEPTH; i++) fetch(32'h800 + 32'(4 * i), "R9");
    chk("R9", "no-ovf-yet", 32'(ovf_flag), 0);
    // trace pops one while capturing: still fits
    step(1, 1, 32'h820, word_of(32'h820), 1, 32'h800, word_of(32'h800), 0, "R9");
    chk("R9", "pop-first", 32'(ovf_flag), 0);
    fetch(32'h824, "R9");
    chk("R9", "ovf", 32'(ovf_flag), 1);
    step(0, 0, 0, 0, 1, 32'h804, 32'h0, 0, "R9");
    chk("R9", "halted-no-err", 32'(err_flag), 0);
    clear("R8");
    chk("R8", "ovf-cleared", 32'(ovf_flag), 0);

    // R10: same-cycle capture not visible to trace
    step(1, 1, 32'hA00, word_of(32'hA00), 1, 32'hA00, word_of(32'hA00), 0, "R10");
    chk("R10", "err_flag", 32'(err_flag), 1);
    chk("R5", "err_word", 32'(err_word), 0);
    clear("R8");

    // Constrained random
    begin
      logic [31:0] fpc = 32'h1000;
      for (int n = 0; n < 4000; n++) begin
        bit f, q, t, c;
        logic [31:0] a, p, w;
        int r;
        f = ($urandom % 3) != 0;
        q = ($urandom % 8) != 0;
        a = fpc;
        if (f && q) begin
          fpc = fpc + 4;
          if ($urandom % 10 == 0) fpc = {$urandom % 32'h400, 2'b00} + 32'h1000;
        end
        t = (($urandom % 2) == 1) && (mq.size() > 0 || ($urandom % 20) == 0);
        r = $urandom % 20;
        if (mq.size() == 0) begin
          p = {$urandom % 32'h400, 2'b00} + 32'h1000; w = word_of(p);
        end else if (r < 15) begin
          p = mq[0][63:32]; w = word_of(p);
        end else if (r < 17) begin
          p = mq[$urandom % mq.size()][63:32]; w = word_of(p);
        end else if (r < 18) begin
          p = {$urandom % 32'h400, 2'b00} + 32'h1000; w = word_of(p);
        end else begin
          p = mq[0][63:32]; w = word_of(p) ^ 32'h10;
        end
        c = (($urandom % 80) == 0) || (m_ovf && ($urandom % 10) == 0)
            || (m_err && ($urandom % 30) == 0);
        step(f, q, a, word_of(a), t, p, w, c, "R10");
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule